// File: doc/BRIEF.md
# Locked Clock Oscillator Control Register

This block holds the settings of two clock synthesizers, one feeding the processor and one feeding the memory. A single 32-bit oscillator register carries, for each synthesizer, an 8-bit VCO multiplier word and a 3-bit output-divider select. The register sits behind a key-protected guard. Writes to it take effect only while a separate guard register holds the unlock key.

The block decodes both settings and drives the resulting output frequency, in kHz, on two plain status buses. Other logic can therefore see the effect of a setting without any analog model.

The register bus is a plain control port: a write strobe, one shared address, write data, and combinational read data for the addressed register. It has no valid/ready handshake, because every access completes in the cycle it is presented.

A third address offers a narrow processor-only update. It rewrites bits 10:0 and keeps the rest of the register. This matches how a speed change is normally applied.

Top module: `clk_osc_ctrl`

## Requirements
- R1: After reset the guard is locked (guard address reads 1), the oscillator register reads 0x00130140, the processor frequency is 72000 and the memory frequency is 28000.
- R2: Writing exactly 0x0000A05F to the guard address (1) unlocks the guard. The guard address then reads 0 from the following cycle.
- R3: Writing any other value to the guard address, zero included, locks the guard. The guard address then reads 1 from the following cycle.
- R4: A write to the oscillator address (0) or to the processor-update address (2) while the guard is locked leaves the oscillator register unchanged.
- R5: While unlocked, a write to address 0 stores all 32 bits. The value reads back from address 0 in the next cycle.
- R6: The processor VCO word is bits 7:0 and the processor divider select is bits 10:8. The memory VCO word is bits 19:12 and the memory divider select is bits 22:20. No other bit affects either frequency.
- R7: Divider selects 0 through 7 choose divisors 10, 2, 8, 4, 5, 7, 9 and 6 respectively.
- R8: Each frequency output equals 2000 × (VCO word + 8) / (divisor × factor), truncated toward zero. The factor is 1 for the processor and 2 for the memory. The output follows the register in the same cycle.
- R9: While unlocked, a write to address 2 replaces only bits 10:0 of the oscillator register with bits 10:0 of the write data. Bits 31:11 keep their value.
- R10: The cpu_vco_ok output is 1 exactly when the processor VCO word lies in the range 4 to 152 inclusive.
- R11: Address 3 reads as zero, and a write to it changes neither the guard nor the oscillator register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W (2) | Register address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| locked | output | 1 | 1 while the guard blocks writes |
| cpu_freq_khz | output | FREQ_W (20) | Processor clock frequency in kHz |
| mem_freq_khz | output | FREQ_W (20) | Memory clock frequency in kHz |
| cpu_vco_ok | output | 1 | Processor VCO word within its legal range |

## Verification
A guard that fails to hold would let a write change the readback on the very next cycle. So locked writes are each followed at once by a readback of address 0, and by the two frequency buses. A wrong guard state shows on the guard readback one cycle after the write that set it, and every transition is checked there.

A slip in a field position or in a divisor table entry moves a frequency output in the same cycle the register changes. The vector walk therefore uses every divider select on both channels, and uses field values at the legal-range edges.

// File: rtl/clk_osc_pkg.sv
package clk_osc_pkg;
  localparam int DATA_W = 32;
  localparam int VDW_W  = 8;
  localparam int SEL_W  = 3;
  localparam int CPU_VDW_LSB = 0;
  localparam int CPU_SEL_LSB = 8;
  localparam int MEM_VDW_LSB = 12;
  localparam int MEM_SEL_LSB = 20;
  localparam int CPU_FIELD_TOP = CPU_SEL_LSB + SEL_W - 1;   // bit 10

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_A05F;
  localparam logic [DATA_W-1:0] OSC_RESET  = 32'h0013_0140;

  localparam int VCO_OFFSET = 8;
  localparam int REF_KHZ    = 2000;
  localparam int VDW_MIN    = 4;
  localparam int VDW_MAX    = 152;

  typedef enum logic [1:0] {
    A_OSC  = 2'd0,
    A_LOCK = 2'd1,
    A_CPU  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  function automatic int unsigned divisor_of(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: divisor_of = 10;
      3'd1: divisor_of = 2;
      3'd2: divisor_of = 8;
      3'd3: divisor_of = 4;
      3'd4: divisor_of = 5;
      3'd5: divisor_of = 7;
      3'd6: divisor_of = 9;
      default: divisor_of = 6;
    endcase
  endfunction
endpackage

// File: rtl/osc_lock_gate.sv
module osc_lock_gate
  import clk_osc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o
);
  logic locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    locked_q <= 1'b1;
    else if (wr_i) locked_q <= (wdata_i != UNLOCK_KEY);
  end

  assign locked_o = locked_q;

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i == UNLOCK_KEY) |=> !locked_o);   // R2
  AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i != UNLOCK_KEY) |=> locked_o);    // R3
  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(locked_o));                     // R3
endmodule

// File: rtl/osc_setting_reg.sv
module osc_setting_reg
  import clk_osc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked_i,
  input  logic              full_wr_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] osc_o
);
  localparam int LOW_W = CPU_FIELD_TOP + 1;

  logic [DATA_W-1:0] osc_q;
  logic [DATA_W-1:0] osc_d;

  always_comb begin
    osc_d = osc_q;
    if (!locked_i) begin
      if (full_wr_i)     osc_d = wdata_i;
      else if (cpu_wr_i) osc_d = {osc_q[DATA_W-1:LOW_W], wdata_i[LOW_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) osc_q <= OSC_RESET;
    else        osc_q <= osc_d;
  end

  assign osc_o = osc_q;

  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    locked_i |=> $stable(osc_o));                                 // R4
  AST_FULL_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_i && full_wr_i) |=> osc_o == $past(wdata_i));        // R5
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_i && cpu_wr_i && !full_wr_i) |=>
      osc_o[DATA_W-1:LOW_W] == $past(osc_o[DATA_W-1:LOW_W]));      // R9
endmodule

// File: rtl/osc_freq_calc.sv
module osc_freq_calc
  import clk_osc_pkg::*;
#(
  parameter int FACTOR = 1,
  parameter int FREQ_W = 20
) (
  input  logic [VDW_W-1:0]  vdw_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [FREQ_W-1:0] freq_o
);
  localparam int unsigned NUM_MAX = REF_KHZ * ((1 << VDW_W) - 1 + VCO_OFFSET);

  int unsigned numer;
  int unsigned denom;
  int unsigned quot;

  always_comb begin
    numer  = REF_KHZ * (32'(vdw_i) + VCO_OFFSET);
    denom  = divisor_of(sel_i) * FACTOR;
    quot   = numer / denom;
    freq_o = FREQ_W'(quot);
  end

  always_comb begin
    AST_FREQ_FITS: assert (quot <= NUM_MAX / 2 / FACTOR);   // R8
  end
endmodule

// File: rtl/clk_osc_ctrl.sv
module clk_osc_ctrl
  import clk_osc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int FREQ_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              locked,
  output logic [FREQ_W-1:0] cpu_freq_khz,
  output logic [FREQ_W-1:0] mem_freq_khz,
  output logic              cpu_vco_ok
);
  localparam int NCH = 2;
  localparam int VDW_LSB [NCH] = '{CPU_VDW_LSB, MEM_VDW_LSB};
  localparam int SEL_LSB [NCH] = '{CPU_SEL_LSB, MEM_SEL_LSB};

  logic              hit_osc, hit_lock, hit_cpu;
  logic [DATA_W-1:0] osc;
  logic [FREQ_W-1:0] freq [NCH];

  assign hit_osc  = (bus_addr == ADDR_W'(A_OSC));
  assign hit_lock = (bus_addr == ADDR_W'(A_LOCK));
  assign hit_cpu  = (bus_addr == ADDR_W'(A_CPU));

  osc_lock_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (bus_wr && hit_lock),
    .wdata_i  (bus_wdata),
    .locked_o (locked)
  );

  osc_setting_reg u_osc (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked_i  (locked),
    .full_wr_i (bus_wr && hit_osc),
    .cpu_wr_i  (bus_wr && hit_cpu),
    .wdata_i   (bus_wdata),
    .osc_o     (osc)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    osc_freq_calc #(
      .FACTOR (ch + 1),
      .FREQ_W (FREQ_W)
    ) u_calc (
      .vdw_i  (osc[VDW_LSB[ch] +: VDW_W]),
      .sel_i  (osc[SEL_LSB[ch] +: SEL_W]),
      .freq_o (freq[ch])
    );
  end

  assign cpu_freq_khz = freq[0];
  assign mem_freq_khz = freq[1];

  logic [VDW_W-1:0] cpu_vdw;
  assign cpu_vdw    = osc[CPU_VDW_LSB +: VDW_W];
  assign cpu_vco_ok = (cpu_vdw >= VDW_W'(VDW_MIN)) && (cpu_vdw <= VDW_W'(VDW_MAX));

  always_comb begin
    bus_rdata = '0;
    if (hit_osc)       bus_rdata = osc;
    else if (hit_lock) bus_rdata = {31'b0, locked};
  end

  AST_RESET_LOCKED: assert property (@(posedge clk)
    !rst_n |=> locked);                                            // R1
  AST_SPARE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_NONE)) |=> $stable(osc) && $stable(locked)); // R11
endmodule

// File: tb/clk_osc_ctrl_bench.sv
`timescale 1ns/1ps
module clk_osc_ctrl_bench;
  localparam int HALF = 2;   // 250 MHz
  localparam int NV = 8;

  // oscillator word, expected cpu kHz, expected mem kHz, expected vco_ok
  localparam logic [31:0] V_OSC [NV] = '{
    32'h0000C002, 32'h001FF104, 32'h00200298, 32'h00301399,
    32'h00405403, 32'h00564564, 32'h006076FF, 32'hA0732F0A };
  localparam int V_CPU [NV] = '{2000, 12000, 40000, 80500, 4400, 30857, 58444, 6000};
  localparam int V_MEM [NV] = '{2000, 131500, 1000, 2250, 2600, 15428, 1666, 9666};
  localparam bit V_OK  [NV] = '{0, 1, 1, 0, 0, 1, 0, 1};

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        locked;
  logic [19:0] cpu_freq_khz, mem_freq_khz;
  logic        cpu_vco_ok;

  int checks = 0;
  int errors = 0;

  always #HALF clk = ~clk;

  clk_osc_ctrl u_clk_osc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .locked(locked),
    .cpu_freq_khz(cpu_freq_khz), .mem_freq_khz(mem_freq_khz),
    .cpu_vco_ok(cpu_vco_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(2 * HALF * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, r); chk("R1 lock readback", r, 32'd1);
    rd(2'd0, r); chk("R1 osc readback", r, 32'h00130140);
    chk("R1 cpu freq", 32'(cpu_freq_khz), 32'd72000);
    chk("R1 mem freq", 32'(mem_freq_khz), 32'd28000);

    // R4 locked writes ignored
    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, r); chk("R4 locked full write", r, 32'h00130140);
    wr(2'd2, 32'h000007FF);
    rd(2'd0, r); chk("R4 locked cpu write", r, 32'h00130140);
    chk("R4 cpu freq unchanged", 32'(cpu_freq_khz), 32'd72000);

    // R2 unlock
    wr(2'd1, 32'h0000A05F);
    rd(2'd1, r); chk("R2 unlocked readback", r, 32'd0);

    // R5 R6 R7 R8 R10 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, V_OSC[i]);
      rd(2'd0, r); chk("R5 full write readback", r, V_OSC[i]);
      chk("R7 R8 cpu freq", 32'(cpu_freq_khz), 32'(V_CPU[i]));
      chk("R6 R8 mem freq", 32'(mem_freq_khz), 32'(V_MEM[i]));
      chk("R10 vco range", 32'(cpu_vco_ok), 32'(V_OK[i]));
    end

    // R9 processor-only update keeps bits 31:11
    wr(2'd2, 32'hFFFFF164);
    rd(2'd0, r); chk("R9 partial update", r, 32'hA0732964);
    chk("R9 cpu freq", 32'(cpu_freq_khz), 32'd108000);
    chk("R9 mem freq kept", 32'(mem_freq_khz), 32'd9666);

    // R11 spare address
    rd(2'd3, r); chk("R11 spare reads zero", r, 32'd0);
    wr(2'd3, 32'h0000A05F);
    rd(2'd0, r); chk("R11 spare write osc", r, 32'hA0732964);
    rd(2'd1, r); chk("R11 spare write lock", r, 32'd0);

    // R3 relock with zero
    wr(2'd1, 32'h00000000);
    rd(2'd1, r); chk("R3 zero relocks", r, 32'd1);
    wr(2'd2, 32'h00000003);
    rd(2'd0, r); chk("R4 R9 cpu write after relock", r, 32'hA0732964);

    // R3 near-miss key also locks
    wr(2'd1, 32'h0000A05F);
    rd(2'd1, r); chk("R2 reopen", r, 32'd0);
    wr(2'd1, 32'h0001A05F);
    rd(2'd1, r); chk("R3 near-miss key locks", r, 32'd1);
    wr(2'd0, 32'h00000000);
    rd(2'd0, r); chk("R4 write after near-miss", r, 32'hA0732964);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule